// File: doc/BRIEF.md
# Lockable Instruction Cache Controller

This block holds the tags, the line storage and the replacement state of a small set-associative instruction cache whose lines can be pinned. A fetch lookup reports hit or miss with the addressed word. A miss fetches the whole line through a refill request/response port, writes it into a victim way and then returns the word. Victims are chosen by a round-robin pointer kept per set, and that pointer steps over any way that is pinned.

A command port carries two operations. The first is lock-line. It takes an address, aligns it to a 32-byte line, brings the line in if it is absent and pins it. The second is global unlock. It drops every pin in one cycle and leaves the lines valid and still able to hit, so they rejoin round-robin replacement. Software locks a routine by issuing lock-line once per line. Such a sequence may stop part way, and the block keeps whatever is already pinned. At least one way of every set always stays unpinned, so a lock that would pin the last free way of a set is refused.

Top module: `icl_lock_ctrl`

## Requirements
- R1: After reset every way is invalid and unpinned, every per-set pointer is at way 0, busy_o, resp_valid_o, cmd_done_o and refill_req_o are low, and the first fetch of any address misses.
- R2: A fetch that hits gives resp_valid_o with resp_hit_o=1 in the cycle after it is accepted. It issues no refill, and resp_word_o is the 32-bit word chosen by address bits [4:2].
- R3: A fetch miss raises refill_req_o and busy_o from the cycle after acceptance. refill_addr_o holds the line address with bits [4:0] at zero. Both drop in the cycle after refill_rsp_valid_i is sampled, and in that same cycle resp_valid_o is given with resp_hit_o=0 and the requested word taken from the returned line. Word k of the line sits at bits [32k+31:32k].
- R4: A fill goes to the first unpinned way found by searching upward, with wraparound, from the set's pointer. The pointer then moves to the way after the victim. Hits do not move it.
- R5: A lock-line command (cmd_unlock_i=0) that hits pins the line without a refill. cmd_done_o is given with cmd_err_o=0 in the next cycle.
- R6: A lock-line command that misses refills the line into the victim way and pins it. cmd_done_o is given with cmd_err_o=0 in the cycle after the refill response.
- R7: A lock-line command that would leave its set with no unpinned way is refused. cmd_done_o is given with cmd_err_o=1 in the next cycle, no refill is issued and no state changes.
- R8: A global unlock command (cmd_unlock_i=1) clears every pin at once and answers with cmd_done_o, cmd_err_o=0. Released lines still hit and are evicted again in round-robin order.
- R9: A pinned line is never chosen as a victim, however many conflicting misses its set sees.
- R10: While busy_o is high, fetch and command inputs are ignored. When both are valid in an idle cycle, the command is served and the fetch is dropped.
- R11: Bits [4:0] of a lock address are ignored, so any address inside a line locks that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_valid_i | input | 1 | Fetch lookup request |
| fetch_addr_i | input | 32 | Fetch byte address |
| cmd_valid_i | input | 1 | Command request |
| cmd_unlock_i | input | 1 | 1: global unlock, 0: lock-line |
| cmd_addr_i | input | 32 | Lock-line address |
| busy_o | output | 1 | Refill in progress; inputs ignored |
| resp_valid_o | output | 1 | Fetch result strobe |
| resp_hit_o | output | 1 | Fetch result was a hit |
| resp_word_o | output | 32 | Fetched word |
| cmd_done_o | output | 1 | Command completion strobe |
| cmd_err_o | output | 1 | Lock-line refused |
| refill_req_o | output | 1 | Refill request, held until response |
| refill_addr_o | output | 32 | Line-aligned refill address |
| refill_rsp_valid_i | input | 1 | Refill data strobe |
| refill_rsp_data_i | input | 256 | Whole returned line |

## Verification
The hardest state to reach is a set that holds three pinned ways with only one unpinned way, and then keeps thrashing. Every conflicting miss must fall into that single way, while a fourth lock attempt must be refused. The stimulus builds this state in set 0 with a lock-miss, a lock at an unaligned address and a lock-hit. It then sends six conflicting misses and checks that all pinned lines still hit. After a global unlock it checks that each released way is evicted in pointer order, one miss at a time, by probing the survivors between misses.

// File: rtl/icl_pkg.sv
package icl_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_REFILL = 1'b1
  } icl_state_e;

  typedef enum logic {
    OP_FETCH = 1'b0,
    OP_LOCK  = 1'b1
  } icl_op_e;
endpackage

// File: rtl/icl_tag_array.sv
module icl_tag_array #(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int TAG_W = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [$clog2(SETS)-1:0] look_set_i,
  input  logic [TAG_W-1:0]        look_tag_i,
  output logic                    hit_o,
  output logic [$clog2(WAYS)-1:0] hit_way_o,
  output logic [WAYS-1:0]         set_locks_o,
  input  logic                    fill_en_i,
  input  logic [$clog2(SETS)-1:0] fill_set_i,
  input  logic [$clog2(WAYS)-1:0] fill_way_i,
  input  logic [TAG_W-1:0]        fill_tag_i,
  input  logic                    fill_lock_i,
  input  logic                    lock_en_i,
  input  logic [$clog2(SETS)-1:0] lock_set_i,
  input  logic [$clog2(WAYS)-1:0] lock_way_i,
  input  logic                    unlock_all_i
);
  localparam int WAY_W = $clog2(WAYS);

  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [SETS-1:0][WAYS-1:0] lock_q;
  logic [TAG_W-1:0]          tag_q [SETS][WAYS];
  logic [WAYS-1:0]           way_hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = valid_q[look_set_i][w] && (tag_q[look_set_i][w] == look_tag_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) hit_way_o = WAY_W'(w);
    end
  end

  assign hit_o       = |way_hit;
  assign set_locks_o = lock_q[look_set_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      lock_q  <= '0;
    end else begin
      if (unlock_all_i) lock_q <= '0;
      if (lock_en_i) lock_q[lock_set_i][lock_way_i] <= 1'b1;
      if (fill_en_i) begin
        valid_q[fill_set_i][fill_way_i] <= 1'b1;
        lock_q[fill_set_i][fill_way_i]  <= fill_lock_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) tag_q[fill_set_i][fill_way_i] <= fill_tag_i;
  end
endmodule

// File: rtl/icl_victim_sel.sv
module icl_victim_sel #(
  parameter int SETS = 8,
  parameter int WAYS = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [$clog2(SETS)-1:0] set_i,
  input  logic [WAYS-1:0]         locks_i,
  output logic [$clog2(WAYS)-1:0] victim_o,
  input  logic                    adv_en_i,
  input  logic [$clog2(SETS)-1:0] adv_set_i,
  input  logic [$clog2(WAYS)-1:0] adv_way_i
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] rr_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_rr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rr_q[s] <= '0;
      else if (adv_en_i && (adv_set_i == s)) rr_q[s] <= WAY_W'(adv_way_i + 1'b1);
    end
  end

  // First unpinned way at or after the pointer, wrapping
  always_comb begin
    logic             found;
    logic [WAY_W-1:0] idx;
    found    = 1'b0;
    victim_o = rr_q[set_i];
    for (int k = 0; k < WAYS; k++) begin
      idx = WAY_W'(rr_q[set_i] + WAY_W'(k));
      if (!found && !locks_i[idx]) begin
        victim_o = idx;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/icl_data_array.sv
module icl_data_array #(
  parameter int SETS   = 8,
  parameter int WAYS   = 4,
  parameter int LINE_W = 256
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [$clog2(SETS)-1:0] wset_i,
  input  logic [$clog2(WAYS)-1:0] wway_i,
  input  logic [LINE_W-1:0]       wdata_i,
  input  logic [$clog2(SETS)-1:0] rset_i,
  input  logic [$clog2(WAYS)-1:0] rway_i,
  output logic [LINE_W-1:0]       rdata_o
);
  localparam int DEPTH = SETS * WAYS;
  localparam int IDX_W = $clog2(DEPTH);

  logic [LINE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[IDX_W'(wset_i * WAYS + wway_i)] <= wdata_i;
  end

  assign rdata_o = mem_q[IDX_W'(rset_i * WAYS + rway_i)];
endmodule

// File: rtl/icl_lock_ctrl.sv
module icl_lock_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WORD_W     = 32,
  parameter int SETS       = 8,
  parameter int WAYS       = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fetch_valid_i,
  input  logic [ADDR_W-1:0]         fetch_addr_i,
  input  logic                      cmd_valid_i,
  input  logic                      cmd_unlock_i,
  input  logic [ADDR_W-1:0]         cmd_addr_i,
  output logic                      busy_o,
  output logic                      resp_valid_o,
  output logic                      resp_hit_o,
  output logic [WORD_W-1:0]         resp_word_o,
  output logic                      cmd_done_o,
  output logic                      cmd_err_o,
  output logic                      refill_req_o,
  output logic [ADDR_W-1:0]         refill_addr_o,
  input  logic                      refill_rsp_valid_i,
  input  logic [LINE_BYTES*8-1:0]   refill_rsp_data_i
);
  import icl_pkg::*;

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int BOFF_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_W - BOFF_W;
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;

  icl_state_e        state_q;
  icl_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WAY_W-1:0]  victim_q;
  logic              resp_valid_q, resp_hit_q, cmd_done_q, cmd_err_q;
  logic [WORD_W-1:0] resp_word_q;

  logic              idle, accept_cmd, accept_fetch;
  logic [ADDR_W-1:0] look_addr;
  logic [SET_W-1:0]  look_set, fill_set;
  logic [TAG_W-1:0]  look_tag, fill_tag;
  logic              hit;
  logic [WAY_W-1:0]  hit_way, victim;
  logic [WAYS-1:0]   set_locks;
  logic [WAY_W:0]    n_locked;
  logic              already_locked, lock_refuse;
  logic              unlock_all, lock_hit_en, fill_en;
  logic [LINE_W-1:0] rd_line;

  function automatic logic [WORD_W-1:0] pick_word(logic [LINE_W-1:0] line,
                                                  logic [WSEL_W-1:0] sel);
    return line[sel*WORD_W +: WORD_W];
  endfunction

  assign idle         = (state_q == ST_IDLE);
  assign accept_cmd   = idle && cmd_valid_i;
  assign accept_fetch = idle && fetch_valid_i && !cmd_valid_i;
  assign look_addr    = cmd_valid_i ? cmd_addr_i : fetch_addr_i;
  assign look_set     = look_addr[OFF_W +: SET_W];
  assign look_tag     = look_addr[ADDR_W-1 -: TAG_W];
  assign fill_set     = addr_q[OFF_W +: SET_W];
  assign fill_tag     = addr_q[ADDR_W-1 -: TAG_W];

  always_comb begin
    n_locked = '0;
    for (int w = 0; w < WAYS; w++) n_locked = n_locked + (WAY_W+1)'(set_locks[w]);
  end

  assign already_locked = hit && set_locks[hit_way];
  assign lock_refuse    = !already_locked && (n_locked == (WAY_W+1)'(WAYS - 1));

  assign unlock_all  = accept_cmd && cmd_unlock_i;
  assign lock_hit_en = accept_cmd && !cmd_unlock_i && !lock_refuse && hit;
  assign fill_en     = (state_q == ST_REFILL) && refill_rsp_valid_i;

  icl_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) i_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .look_set_i   (look_set),
    .look_tag_i   (look_tag),
    .hit_o        (hit),
    .hit_way_o    (hit_way),
    .set_locks_o  (set_locks),
    .fill_en_i    (fill_en),
    .fill_set_i   (fill_set),
    .fill_way_i   (victim_q),
    .fill_tag_i   (fill_tag),
    .fill_lock_i  (op_q == OP_LOCK),
    .lock_en_i    (lock_hit_en),
    .lock_set_i   (look_set),
    .lock_way_i   (hit_way),
    .unlock_all_i (unlock_all)
  );

  icl_victim_sel #(.SETS(SETS), .WAYS(WAYS)) i_victim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (look_set),
    .locks_i   (set_locks),
    .victim_o  (victim),
    .adv_en_i  (fill_en),
    .adv_set_i (fill_set),
    .adv_way_i (victim_q)
  );

  icl_data_array #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W)) i_data (
    .clk_i   (clk_i),
    .we_i    (fill_en),
    .wset_i  (fill_set),
    .wway_i  (victim_q),
    .wdata_i (refill_rsp_data_i),
    .rset_i  (look_set),
    .rway_i  (hit_way),
    .rdata_o (rd_line)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      op_q         <= OP_FETCH;
      addr_q       <= '0;
      victim_q     <= '0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_word_q  <= '0;
      cmd_done_q   <= 1'b0;
      cmd_err_q    <= 1'b0;
    end else begin
      resp_valid_q <= 1'b0;
      cmd_done_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_cmd) begin
            if (cmd_unlock_i || hit || lock_refuse) begin
              cmd_done_q <= 1'b1;
              cmd_err_q  <= !cmd_unlock_i && lock_refuse;
            end else begin
              state_q  <= ST_REFILL;
              op_q     <= OP_LOCK;
              addr_q   <= look_addr;
              victim_q <= victim;
            end
          end else if (accept_fetch) begin
            if (hit) begin
              resp_valid_q <= 1'b1;
              resp_hit_q   <= 1'b1;
              resp_word_q  <= pick_word(rd_line, look_addr[BOFF_W +: WSEL_W]);
            end else begin
              state_q  <= ST_REFILL;
              op_q     <= OP_FETCH;
              addr_q   <= look_addr;
              victim_q <= victim;
            end
          end
        end
        ST_REFILL: begin
          if (refill_rsp_valid_i) begin
            state_q <= ST_IDLE;
            if (op_q == OP_FETCH) begin
              resp_valid_q <= 1'b1;
              resp_hit_q   <= 1'b0;
              resp_word_q  <= pick_word(refill_rsp_data_i, addr_q[BOFF_W +: WSEL_W]);
            end else begin
              cmd_done_q <= 1'b1;
              cmd_err_q  <= 1'b0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = !idle;
  assign refill_req_o  = (state_q == ST_REFILL);
  assign refill_addr_o = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign resp_valid_o  = resp_valid_q;
  assign resp_hit_o    = resp_hit_q;
  assign resp_word_o   = resp_word_q;
  assign cmd_done_o    = cmd_done_q;
  assign cmd_err_o     = cmd_err_q;
endmodule

// File: rtl/icl_checker.sv
module icl_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int SETS   = 8,
  parameter int WAYS   = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      busy_o,
  input logic                      resp_valid_o,
  input logic                      resp_hit_o,
  input logic                      cmd_done_o,
  input logic                      cmd_err_o,
  input logic                      refill_req_o,
  input logic [ADDR_W-1:0]         refill_addr_o,
  input logic                      refill_rsp_valid_i,
  input logic                      unlock_all,
  input logic [SETS-1:0][WAYS-1:0] lock_q
);
  assert_refill_aligned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_req_o |-> (refill_addr_o[OFF_W-1:0] == '0));

  assert_refill_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_req_o && refill_rsp_valid_i) |=> (!refill_req_o && !busy_o));

  assert_hit_no_refill_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_hit_o) |-> $past(!refill_req_o));

  assert_refuse_no_refill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_done_o && cmd_err_o) |-> (!refill_req_o && $past(!refill_req_o)));

  assert_unlock_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_all |=> (lock_q == '0));

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o || cmd_done_o) |-> !busy_o);

  for (genvar s = 0; s < SETS; s++) begin : g_free
    assert_free_way_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(&lock_q[s]));
  end
endmodule

bind icl_lock_ctrl icl_checker #(
  .ADDR_W (ADDR_W),
  .OFF_W  ($clog2(LINE_BYTES)),
  .SETS   (SETS),
  .WAYS   (WAYS)
) i_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .busy_o             (busy_o),
  .resp_valid_o       (resp_valid_o),
  .resp_hit_o         (resp_hit_o),
  .cmd_done_o         (cmd_done_o),
  .cmd_err_o          (cmd_err_o),
  .refill_req_o       (refill_req_o),
  .refill_addr_o      (refill_addr_o),
  .refill_rsp_valid_i (refill_rsp_valid_i),
  .unlock_all         (unlock_all),
  .lock_q             (i_tags.lock_q)
);

// File: tb/test_icl_lock_ctrl.sv
`timescale 1ns/1ps
module test_icl_lock_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fetch_valid = 1'b0;
  logic [31:0]  fetch_addr = '0;
  logic         cmd_valid = 1'b0;
  logic         cmd_unlock = 1'b0;
  logic [31:0]  cmd_addr = '0;
  logic         busy, resp_valid, resp_hit, cmd_done, cmd_err, refill_req;
  logic [31:0]  resp_word, refill_addr;
  logic         rsp_valid = 1'b0;
  logic [255:0] rsp_data = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int refills  = 0;

  typedef struct {
    bit          is_cmd;
    bit          hit;
    bit          err;
    logic [31:0] word;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  icl_lock_ctrl i_icl_lock_ctrl (
    .clk_i              (clk),
    .rst_ni             (rst_n),
    .fetch_valid_i      (fetch_valid),
    .fetch_addr_i       (fetch_addr),
    .cmd_valid_i        (cmd_valid),
    .cmd_unlock_i       (cmd_unlock),
    .cmd_addr_i         (cmd_addr),
    .busy_o             (busy),
    .resp_valid_o       (resp_valid),
    .resp_hit_o         (resp_hit),
    .resp_word_o        (resp_word),
    .cmd_done_o         (cmd_done),
    .cmd_err_o          (cmd_err),
    .refill_req_o       (refill_req),
    .refill_addr_o      (refill_addr),
    .refill_rsp_valid_i (rsp_valid),
    .refill_rsp_data_i  (rsp_data)
  );

  function automatic logic [31:0] word_of(logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hA5A5_0000;
  endfunction

  function automatic logic [255:0] line_of(logic [31:0] a);
    logic [255:0] l;
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = word_of({a[31:5], 3'(i), 2'b00});
    return l;
  endfunction

  function automatic logic [31:0] a0(int n);  // set 0
    return 32'(n * 256);
  endfunction

  function automatic logic [31:0] a1(int n);  // set 1
    return 32'(n * 256 + 32);
  endfunction

  function automatic logic [31:0] a2(int n);  // set 2
    return 32'(n * 256 + 64);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: pop and compare
  always @(negedge clk) begin
    if (rst_n && (resp_valid || cmd_done)) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R10", "unexpected response", {30'd0, cmd_done, resp_valid}, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.is_cmd == cmd_done, e.req, "response kind", 32'(cmd_done), 32'(e.is_cmd));
        if (e.is_cmd) begin
          chk(cmd_err == e.err, e.req, "cmd_err", 32'(cmd_err), 32'(e.err));
        end else begin
          chk(resp_hit == e.hit, e.req, "resp_hit", 32'(resp_hit), 32'(e.hit));
          chk(resp_word == e.word, e.req, "resp_word", resp_word, e.word);
        end
      end
    end
  end

  // Refill responder, two idle cycles of latency
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && refill_req && !rsp_valid) begin
        refills++;
        chk(refill_addr[4:0] == 5'd0, "R3", "refill alignment", refill_addr, {refill_addr[31:5], 5'd0});
        chk(busy, "R3", "busy during refill", 32'(busy), 32'd1);
        repeat (2) @(negedge clk);
        rsp_data  = line_of(refill_addr);
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic do_fetch(logic [31:0] a, bit exp_hit, string req);
    exp_t e;
    wait_idle();
    e = '{is_cmd: 1'b0, hit: exp_hit, err: 1'b0, word: word_of(a), req: req};
    sb.push_back(e);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    @(negedge clk);
    fetch_valid = 1'b0;
    drain();
  endtask

  task automatic do_cmd(bit unlock, logic [31:0] a, bit exp_err, string req);
    exp_t e;
    wait_idle();
    e = '{is_cmd: 1'b1, hit: 1'b0, err: exp_err, word: '0, req: req};
    sb.push_back(e);
    cmd_valid  = 1'b1;
    cmd_unlock = unlock;
    cmd_addr   = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    drain();
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", "run timed out", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int r0;
    repeat (5) @(negedge clk);
    chk(!busy && !resp_valid && !cmd_done && !refill_req, "R1", "outputs after reset",
        {28'd0, busy, resp_valid, cmd_done, refill_req}, 32'd0);
    rst_n = 1'b1;

    // R1/R2/R3: cold miss, then hit on another word
    do_fetch(a1(0) + 32'h8, 1'b0, "R1");
    do_fetch(a1(0) + 32'h14, 1'b1, "R2");
    // R4: round robin in set 1
    do_fetch(a1(1), 1'b0, "R4");
    do_fetch(a1(2), 1'b0, "R4");
    do_fetch(a1(3) + 32'h1c, 1'b0, "R3");
    do_fetch(a1(0), 1'b1, "R4");
    do_fetch(a1(4), 1'b0, "R4");
    do_fetch(a1(1), 1'b1, "R4");
    do_fetch(a1(0), 1'b0, "R4");

    // Build three pinned ways in set 0
    do_fetch(a0(0), 1'b0, "R3");
    do_cmd(1'b0, a0(1), 1'b0, "R6");
    do_cmd(1'b0, a0(2) + 32'h1c, 1'b0, "R11");
    do_fetch(a0(2) + 32'h4, 1'b1, "R11");
    r0 = refills;
    do_cmd(1'b0, a0(0) + 32'h10, 1'b0, "R5");
    chk(refills == r0, "R5", "refills on lock hit", 32'(refills), 32'(r0));
    do_cmd(1'b0, a0(3), 1'b1, "R7");
    chk(refills == r0, "R7", "refills on refused lock", 32'(refills), 32'(r0));
    do_cmd(1'b0, a0(1) + 32'h3, 1'b0, "R5");  // already pinned

    // R9: conflicting misses all land in the one free way
    for (int n = 4; n < 10; n++) do_fetch(a0(n), 1'b0, "R9");
    do_fetch(a0(0), 1'b1, "R9");
    do_fetch(a0(1), 1'b1, "R9");
    do_fetch(a0(2), 1'b1, "R9");
    do_fetch(a0(9), 1'b1, "R9");
    do_fetch(a0(8), 1'b0, "R9");
    do_fetch(a0(3), 1'b0, "R7");  // refused lock left nothing resident
    do_fetch(a0(8), 1'b0, "R9");  // a0(3) took the free way

    // R8: global unlock, lines stay valid then rotate out in order
    do_cmd(1'b1, 32'h0, 1'b0, "R8");
    do_fetch(a0(0), 1'b1, "R8");
    do_fetch(a0(1), 1'b1, "R8");
    do_fetch(a0(2), 1'b1, "R8");
    do_fetch(a0(8), 1'b1, "R8");
    do_fetch(a0(10), 1'b0, "R8");
    do_fetch(a0(1), 1'b1, "R8");
    do_fetch(a0(2), 1'b1, "R8");
    do_fetch(a0(8), 1'b1, "R8");
    do_fetch(a0(11), 1'b0, "R8");
    do_fetch(a0(2), 1'b1, "R8");
    do_fetch(a0(8), 1'b1, "R8");
    do_fetch(a0(12), 1'b0, "R8");
    do_fetch(a0(8), 1'b1, "R8");
    do_fetch(a0(13), 1'b0, "R8");
    do_fetch(a0(10), 1'b1, "R4");
    do_fetch(a0(13), 1'b1, "R4");
    do_fetch(a0(0), 1'b0, "R8");

    // R10: inputs during a refill are ignored
    begin
      exp_t e;
      wait_idle();
      r0 = refills;
      e = '{is_cmd: 1'b0, hit: 1'b0, err: 1'b0, word: word_of(a2(0)), req: "R10"};
      sb.push_back(e);
      fetch_valid = 1'b1;
      fetch_addr  = a2(0);
      @(negedge clk);
      fetch_addr = a2(5);
      cmd_valid  = 1'b1;
      cmd_unlock = 1'b0;
      cmd_addr   = a2(6);
      @(negedge clk);
      fetch_valid = 1'b0;
      cmd_valid   = 1'b0;
      drain();
      repeat (3) @(negedge clk);
      chk(refills == r0 + 1, "R10", "refills while busy", 32'(refills), 32'(r0 + 1));
    end
    do_fetch(a2(5), 1'b0, "R10");
    // R10: command and fetch together, command wins
    begin
      exp_t e;
      wait_idle();
      e = '{is_cmd: 1'b1, hit: 1'b0, err: 1'b0, word: '0, req: "R10"};
      sb.push_back(e);
      cmd_valid   = 1'b1;
      cmd_unlock  = 1'b1;
      fetch_valid = 1'b1;
      fetch_addr  = a2(5);
      @(negedge clk);
      cmd_valid   = 1'b0;
      fetch_valid = 1'b0;
      drain();
      repeat (3) @(negedge clk);
    end
    do_fetch(a2(5), 1'b1, "R10");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule